// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block sits between the status sources of a 16550-style serial port and the host interrupt controller. It holds the four-bit interrupt-enable register, watches the line error bits, the data-ready flag, the receive FIFO fill level against its trigger level, a character-timeout flag, the transmit holding register empty state and the modem status change bits. Each clock it selects the most urgent enabled source, encodes it into the identification byte, and drives a single level-sensitive interrupt request.

The transmit-empty source is not a plain level. It becomes pending when the holding register goes empty, or when software writes the enable register while the holding register is empty. It drops when software reads the identification byte or when the holding register is filled again. The FIFO storage, the serializer and the baud generator live elsewhere and feed this block through its status inputs.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, the enable register reads 0x00, the identification byte reads 0x01 and irqOut is low.
- R2: irqOut is high exactly when the low nibble of the identification byte differs from 0x1. A low nibble of 0x1 means no source is pending.
- R3: With enable bit 2 set and any bit of lineErr set, the low nibble is 0x6. This source wins over every other source.
- R4: With enable bit 0 set and timeoutPend high, the low nibble is 0xC. This source wins over received data, transmit empty and modem status.
- R5: With fifoEn high, enable bit 0 set and dataReady high, the received-data source (low nibble 0x4) is pending only when rxCount is greater than or equal to trigLevel. Below that level, a lower source is reported, or 0x1 if none is pending.
- R6: With fifoEn low, enable bit 0 set and dataReady high, the received-data code 0x4 is reported whatever rxCount and trigLevel hold.
- R7: The transmit-empty source (code 0x2, enable bit 1) becomes pending on a rising edge of txEmpty, or on an enable write while txEmpty is high. It is cleared by a read of the identification byte, and it is cleared while txEmpty is low.
- R8: With enable bit 3 set and any bit of modemDelta set, and no higher source pending, the low nibble is 0x0.
- R9: An enable write keeps only wrData[3:0]. ierOut[7:4] always read zero.
- R10: Identification bits 7:6 read 11 while fifoEn is high and 00 while it is low. Bits 5:4 read zero.
- R11: A source whose enable bit is clear never produces its code, and with all enable bits clear the identification byte low nibble stays 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ierWrEn | input | 1 | Write strobe for the enable register |
| wrData | input | 8 | Write data for the enable register |
| iirRdEn | input | 1 | Read strobe for the identification byte |
| lineErr | input | 4 | Overrun, parity, framing and break error flags |
| dataReady | input | 1 | Receive data is available |
| fifoEn | input | 1 | FIFO mode is active |
| rxCount | input | CNT_W | Receive FIFO fill count |
| trigLevel | input | CNT_W | Receive FIFO trigger level |
| timeoutPend | input | 1 | Character timeout is pending |
| txEmpty | input | 1 | Transmit holding register is empty |
| modemDelta | input | 4 | Modem status change flags |
| ierOut | output | 8 | Enable register read value |
| iirOut | output | 8 | Identification byte read value |
| irqOut | output | 1 | Interrupt request level |

## Verification
On every cycle, the assertions check the following. The interrupt line agrees with the identification nibble. Enabled line errors produce code 0x6 one clock later. An all-clear enable register yields no interrupt. The FIFO-mode bits follow fifoEn. The upper enable bits stay zero. The bench scenarios cover the remaining behaviour, which depends on a history of strobes and levels. This includes the full priority walk-down as sources drop away one by one, and the trigger-level threshold in FIFO mode. It also covers the transmit-empty flag being armed by an edge or an enable write and then dropped by an identification read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam logic [3:0] CODE_NONE  = 4'h1;
  localparam logic [3:0] CODE_LINE  = 4'h6;
  localparam logic [3:0] CODE_TMO   = 4'hC;
  localparam logic [3:0] CODE_RXD   = 4'h4;
  localparam logic [3:0] CODE_THRE  = 4'h2;
  localparam logic [3:0] CODE_MODEM = 4'h0;

  // enable register bit positions
  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  typedef struct packed {
    logic ierLoad;
    logic pendSet;
    logic pendClr;
  } ctrlStrobes_t;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ierWrEn,
  input  logic         iirRdEn,
  input  logic         txEmpty,
  output ctrlStrobes_t strobes
);

  logic txEmptyQ;

  always_ff @(posedge clk) begin
    if (!rstN) txEmptyQ <= 1'b1;
    else       txEmptyQ <= txEmpty;
  end

  always_comb begin
    strobes.ierLoad = ierWrEn;
    // R7: arm on the empty edge or on an enable write while empty
    strobes.pendSet = (txEmpty && !txEmptyQ) || (ierWrEn && txEmpty);
    strobes.pendClr = iirRdEn || !txEmpty;
  end

endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [7:0]       wrData,
  input  logic [3:0]       lineErr,
  input  logic             dataReady,
  input  logic             fifoEn,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             timeoutPend,
  input  logic [3:0]       modemDelta,
  output logic [7:0]       ierOut,
  output logic [7:0]       iirOut,
  output logic             irqOut
);

  logic [3:0] ierQ;
  logic       threPend;
  logic [3:0] codeNext;
  logic       rxSrc;
  logic [3:0] codeQ;
  logic       fifoQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ierQ     <= '0;
      threPend <= 1'b0;
    end else begin
      if (strobes.ierLoad) ierQ <= wrData[3:0];
      if (strobes.pendSet)      threPend <= 1'b1;
      else if (strobes.pendClr) threPend <= 1'b0;
    end
  end

  always_comb begin
    rxSrc = dataReady && (!fifoEn || (rxCount >= trigLevel));
    codeNext = CODE_NONE;
    if (ierQ[EN_LINE] && |lineErr)          codeNext = CODE_LINE;
    else if (ierQ[EN_RX] && timeoutPend)    codeNext = CODE_TMO;
    else if (ierQ[EN_RX] && rxSrc)          codeNext = CODE_RXD;
    else if (ierQ[EN_TX] && threPend)       codeNext = CODE_THRE;
    else if (ierQ[EN_MODEM] && |modemDelta) codeNext = CODE_MODEM;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ  <= CODE_NONE;
      fifoQ  <= 1'b0;
      irqOut <= 1'b0;
    end else begin
      codeQ  <= codeNext;
      fifoQ  <= fifoEn;
      irqOut <= (codeNext != CODE_NONE);
    end
  end

  assign ierOut = {4'b0000, ierQ};
  assign iirOut = {{2{fifoQ}}, 2'b00, codeQ};

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ierWrEn,
  input  logic [7:0]       wrData,
  input  logic             iirRdEn,
  input  logic [3:0]       lineErr,
  input  logic             dataReady,
  input  logic             fifoEn,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             timeoutPend,
  input  logic             txEmpty,
  input  logic [3:0]       modemDelta,
  output logic [7:0]       ierOut,
  output logic [7:0]       iirOut,
  output logic             irqOut
);

  ctrlStrobes_t strobes;

  uart_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ierWrEn(ierWrEn), .iirRdEn(iirRdEn),
    .txEmpty(txEmpty), .strobes(strobes)
  );

  uart_irq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .lineErr(lineErr), .dataReady(dataReady), .fifoEn(fifoEn),
    .rxCount(rxCount), .trigLevel(trigLevel), .timeoutPend(timeoutPend),
    .modemDelta(modemDelta), .ierOut(ierOut), .iirOut(iirOut),
    .irqOut(irqOut)
  );

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] lineErr,
  input logic       fifoEn,
  input logic [7:0] ierOut,
  input logic [7:0] iirOut,
  input logic       irqOut
);

  // R2
  irq_matches_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (iirOut[3:0] != 4'h1));

  // R3
  line_err_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ierOut[2] && |lineErr) |=> (iirOut[3:0] == 4'h6));

  // R11
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ierOut[3:0] == 4'h0) |=> (iirOut[3:0] == 4'h1 && !irqOut));

  // R10
  fifo_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (iirOut[7:6] == {2{$past(fifoEn)}} && iirOut[5:4] == 2'b00));

  // R9
  ier_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ierOut[7:4] == 4'h0);

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rstN(rstN), .lineErr(lineErr), .fifoEn(fifoEn),
  .ierOut(ierOut), .iirOut(iirOut), .irqOut(irqOut)
);

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;

  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rstN;
  logic          ierWrEn, iirRdEn, dataReady, fifoEn, timeoutPend, txEmpty;
  logic [7:0]    wrData;
  logic [3:0]    lineErr, modemDelta;
  logic [CW-1:0] rxCount, trigLevel;
  logic [7:0]    ierOut, iirOut;
  logic          irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rstN(rstN), .ierWrEn(ierWrEn), .wrData(wrData),
    .iirRdEn(iirRdEn), .lineErr(lineErr), .dataReady(dataReady),
    .fifoEn(fifoEn), .rxCount(rxCount), .trigLevel(trigLevel),
    .timeoutPend(timeoutPend), .txEmpty(txEmpty), .modemDelta(modemDelta),
    .ierOut(ierOut), .iirOut(iirOut), .irqOut(irqOut)
  );

  task automatic settle();
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic checkIid(string req, logic [7:0] exp);
    check8(req, iirOut, exp);
    check8({req, " irq"}, {7'd0, irqOut}, {7'd0, exp[3:0] != 4'h1});
  endtask

  task automatic writeIer(logic [7:0] v);
    @(negedge clk); ierWrEn = 1'b1; wrData = v;
    @(negedge clk); ierWrEn = 1'b0;
  endtask

  task automatic readIid();
    @(negedge clk); iirRdEn = 1'b1;
    @(negedge clk); iirRdEn = 1'b0;
  endtask

  task automatic quiet();
    @(negedge clk);
    lineErr = 0; dataReady = 0; fifoEn = 0; timeoutPend = 0;
    modemDelta = 0; rxCount = 0; trigLevel = 0; txEmpty = 0;
  endtask

  task automatic testReset();
    quiet();
    rstN = 1'b0; ierWrEn = 0; iirRdEn = 0; wrData = 0;
    txEmpty = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check8("R1 ier", ierOut, 8'h00);
    check8("R1 iir", iirOut, 8'h01);
    check8("R1 irq", {7'd0, irqOut}, 8'h00);
    @(negedge clk); rstN = 1'b1;
    settle();
    checkIid("R1 after release", 8'h01);
  endtask

  task automatic testIerMask();
    writeIer(8'hFF);
    settle();
    check8("R9 ier upper", ierOut, 8'h0F);
    quiet();
    writeIer(8'h00);
    @(negedge clk);
    lineErr = 4'hF; timeoutPend = 1; dataReady = 1; modemDelta = 4'hF;
    txEmpty = 1;
    settle();
    checkIid("R11 all masked", 8'h01);
    quiet();
  endtask

  task automatic testPriorityWalk();
    writeIer(8'h0F);
    @(negedge clk);
    txEmpty = 1'b1;
    lineErr = 4'b0100; timeoutPend = 1; dataReady = 1; modemDelta = 4'b0010;
    settle();
    checkIid("R3 line first", 8'h06);
    @(negedge clk); lineErr = 0;
    settle();
    checkIid("R4 timeout", 8'h0C);
    @(negedge clk); timeoutPend = 0;
    settle();
    checkIid("R6 rx data no fifo", 8'h04);
    @(negedge clk); dataReady = 0;
    settle();
    checkIid("R7 thre pending", 8'h02);
    readIid();
    settle();
    checkIid("R8 modem after iir read R7", 8'h00);
    @(negedge clk); modemDelta = 0;
    settle();
    checkIid("R2 none", 8'h01);
    quiet();
  endtask

  task automatic testTrigger();
    writeIer(8'h01);
    @(negedge clk);
    fifoEn = 1; dataReady = 1; trigLevel = 5'd4; rxCount = 5'd3;
    settle();
    checkIid("R5 below trigger", 8'hC1);
    @(negedge clk); rxCount = 5'd4;
    settle();
    checkIid("R5 at trigger", 8'hC4);
    @(negedge clk); rxCount = 5'd14;
    settle();
    checkIid("R5 above trigger", 8'hC4);
    @(negedge clk); fifoEn = 0; rxCount = 5'd0;
    settle();
    checkIid("R10 R6 fifo off", 8'h04);
    quiet();
  endtask

  task automatic testBelowTriggerFalls();
    writeIer(8'h09);
    @(negedge clk);
    fifoEn = 1; dataReady = 1; trigLevel = 5'd8; rxCount = 5'd2;
    modemDelta = 4'b1000;
    settle();
    checkIid("R5 falls to modem", 8'hC0);
    quiet();
  endtask

  task automatic testThreArm();
    writeIer(8'h02);
    settle();
    checkIid("R7 empty low idle", 8'h01);
    @(negedge clk); txEmpty = 1;
    settle();
    checkIid("R7 rising edge", 8'h02);
    readIid();
    settle();
    checkIid("R7 cleared by read", 8'h01);
    writeIer(8'h02);
    settle();
    checkIid("R7 rearm by ier write", 8'h02);
    @(negedge clk); txEmpty = 0;
    settle();
    checkIid("R7 cleared by fill", 8'h01);
    quiet();
  endtask

  initial begin
    testReset();
    testIerMask();
    testPriorityWalk();
    testTrigger();
    testBelowTriggerFalls();
    testThreArm();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule